// File: doc/BRIEF.md
# Cascaded Two-Line Video Delay Memory

This block delays a stream of pixels by one video line and by two video lines at once. Pixels arrive on a write clock and are stored in a first line memory. On a separate read clock, the block reads that memory back and presents each word on a one-line tap. In the same read cycle it also presents the word held in a second line memory on a two-line tap. The word just read from the first memory is copied into the second memory at the same position, so the second memory always trails the first by one line.

Line boundaries are set by the user. A write reset starts every incoming line, and a read reset starts every outgoing line, spaced one line later. Each clock domain has its own three-state controller per address counter. The states are HOLD (counter parked, no memory access), CLEAR (counter forced to zero) and STEP (memory accessed, counter advanced). A low reset input moves the controller into CLEAR from any state. A high reset with a low enable moves it into STEP. Any other input combination moves it into HOLD. The read controller's state also gives the output enable: the taps are driven only after a STEP cycle. A pad ring would turn this enable into a high-impedance output.

Top module: `two_line_delay`

## Requirements
- R1: On a rising `wck` edge with `wres_n` high and `we_n` low, `din` is stored at the current write address, and the write address then advances by one.
- R2: On a rising `wck` edge with `wres_n` high and `we_n` high, nothing is stored and the write address keeps its value, so the next stored word lands where the previous one would have gone next.
- R3: On a rising `wck` edge with `wres_n` low, the write address becomes zero and nothing is stored, even if `we_n` is low. The next stored word goes to address 0.
- R4: On a rising `rck` edge with `rres_n` high and `re_n` low, `q0` takes the word at the read address of the first memory, `q1` takes the word at the same position of the second memory, `q_oe` becomes 1, and the read position advances. With resets spaced one line apart, `q0` equals the pixel written at that position one line earlier.
- R5: In every such read cycle, the word loaded into `q0` is written into the second memory at the current read position, after that position's old content has been loaded into `q1`. `q1` therefore equals the pixel written two lines earlier.
- R6: On a rising `rck` edge with `rres_n` high and `re_n` high, `q_oe` becomes 0, `q0` and `q1` hold their values, the second memory is not written, and the read position does not move.
- R7: On a rising `rck` edge with `rres_n` low, the read position of both memories and the write position of the second memory become zero. No read takes place and `q_oe` becomes 0, even if `re_n` is low.
- R8: Every address counter wraps from DEPTH-1 to 0, so a line longer than DEPTH overwrites its own oldest words and reads back modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wck | input | 1 | Write clock |
| wres_n | input | 1 | Write-address reset, active low, sampled on `wck` |
| we_n | input | 1 | Write enable, active low |
| din | input | PIX_W | Incoming pixel |
| rck | input | 1 | Read clock |
| rres_n | input | 1 | Read-side reset, active low, sampled on `rck` |
| re_n | input | 1 | Read enable, active low |
| q0 | output | PIX_W | One-line-delayed tap |
| q1 | output | PIX_W | Two-line-delayed tap |
| q_oe | output | 1 | 1 when both taps carry data read on the last `rck` edge; 0 means high impedance |

## Verification
The assertions check on every clock edge that each counter steps by one, parks, clears and wraps as its controller state dictates. On the read side they also check that the taps freeze and `q_oe` drops whenever no read is performed. Only the bench scenarios can show that the data itself is correct. This covers the one-line and two-line delays over several lines, the effect of pauses in the middle of a line on either side, a reset that arrives together with an active enable, and the content left behind by a line longer than the memory.

// File: rtl/linebuf_pkg.sv
package linebuf_pkg;
    parameter int PIX_W = 8;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2
    } lb_act_e;
endpackage

// File: rtl/lb_addr_ctl.sv
module lb_addr_ctl
    import linebuf_pkg::*;
#(
    parameter int DEPTH = 5120,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          clr_n,
    input  logic          en_n,
    output logic [AW-1:0] addr,
    output logic          go,
    output lb_act_e       act
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    lb_act_e nxt;

    // next-action decode: clear wins over enable
    always_comb begin
        unique case ({clr_n, en_n})
            2'b00, 2'b01: nxt = ACT_CLEAR;
            2'b10:        nxt = ACT_STEP;
            default:      nxt = ACT_HOLD;
        endcase
    end

    assign go = (nxt == ACT_STEP);

    // state register and counter
    always_ff @(posedge clk) begin
        act <= nxt;
        unique case (nxt)
            ACT_CLEAR: addr <= '0;
            ACT_STEP:  addr <= (addr == LAST) ? '0 : addr + 1'b1;
            default:   addr <= addr;
        endcase
    end

    // R2 / R6: disabled counter parks
    assert_hold_parks_R2: assert property (@(posedge clk) disable iff (!clr_n)
        en_n |=> $stable(addr));

    // R1 / R4: enabled counter advances by one below the top
    assert_step_advances_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_n && addr != LAST) |=> addr == $past(addr) + 1'b1);

    // R8: enabled counter at the top returns to zero
    assert_step_wraps_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_n && addr == LAST) |=> addr == '0);
endmodule

// File: rtl/lb_line_ram.sv
module lb_line_ram #(
    parameter int DEPTH = 5120,
    parameter int W     = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rword
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rword = mem[raddr];
endmodule

// File: rtl/two_line_delay.sv
module two_line_delay
    import linebuf_pkg::*;
#(
    parameter int DEPTH = 5120,
    parameter int W     = PIX_W
) (
    input  logic         wck,
    input  logic         wres_n,
    input  logic         we_n,
    input  logic [W-1:0] din,
    input  logic         rck,
    input  logic         rres_n,
    input  logic         re_n,
    output logic [W-1:0] q0,
    output logic [W-1:0] q1,
    output logic         q_oe
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] wr_addr, rd_addr;
    logic          wr_go, rd_go;
    lb_act_e       wr_act, rd_act;
    logic [W-1:0]  l1_word, l2_word;

    lb_addr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_wr_ctl (
        .clk(wck), .clr_n(wres_n), .en_n(we_n),
        .addr(wr_addr), .go(wr_go), .act(wr_act)
    );

    // one counter serves line-1 read, line-2 read and line-2 write
    lb_addr_ctl #(.DEPTH(DEPTH), .AW(AW)) u_rd_ctl (
        .clk(rck), .clr_n(rres_n), .en_n(re_n),
        .addr(rd_addr), .go(rd_go), .act(rd_act)
    );

    lb_line_ram #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_line1 (
        .wclk(wck), .we(wr_go), .waddr(wr_addr), .wdata(din),
        .raddr(rd_addr), .rword(l1_word)
    );

    // read-before-write at the shared position gives the two-line tap
    lb_line_ram #(.DEPTH(DEPTH), .W(W), .AW(AW)) u_line2 (
        .wclk(rck), .we(rd_go), .waddr(rd_addr), .wdata(l1_word),
        .raddr(rd_addr), .rword(l2_word)
    );

    // output process: taps load only on a STEP decision
    always_ff @(posedge rck) begin
        if (rd_go) begin
            q0 <= l1_word;
            q1 <= l2_word;
        end
    end

    assign q_oe = (rd_act == ACT_STEP);

    // R3: a clear cycle leaves the write address at zero
    assert_wr_clear_R3: assert property (@(posedge wck) disable iff (!wres_n)
        (wr_act == ACT_CLEAR) |-> wr_addr == '0);

    // R7: read reset zeroes the shared position and blanks the taps
    assert_rd_clear_R7: assert property (@(posedge rck)
        !rres_n |=> (rd_addr == '0) && !q_oe);

    // R6: no read means frozen, blanked taps
    assert_no_read_R6: assert property (@(posedge rck) disable iff (!rres_n)
        re_n |=> $stable(q0) && $stable(q1) && !q_oe);

    // R4: a read cycle enables the taps
    assert_read_drives_R4: assert property (@(posedge rck) disable iff (!rres_n)
        !re_n |=> q_oe);
endmodule

// File: tb/test_two_line_delay.sv
module test_two_line_delay;
    localparam int D = 16;
    localparam int L = 12;
    localparam int KW = 50;
    localparam int NW = 3;

    logic       wck = 1'b0, rck = 1'b0;
    logic       wres_n = 1'b0, we_n = 1'b1, rres_n = 1'b0, re_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] q0, q1;
    logic       q_oe;

    int n_cmp = 0;
    int n_bad = 0;

    two_line_delay #(.DEPTH(D), .W(8)) i_two_line_delay (
        .wck(wck), .wres_n(wres_n), .we_n(we_n), .din(din),
        .rck(rck), .rres_n(rres_n), .re_n(re_n),
        .q0(q0), .q1(q1), .q_oe(q_oe)
    );

    always #10 wck = ~wck;
    initial begin
        #5;
        forever #10 rck = ~rck;
    end

    function automatic int pix(input int k, input int x);
        return (k * 37 + x * 5 + 3) & 255;
    endfunction

    // content of address a after the over-long line KW
    function automatic int wrapped(input int a);
        return (a < NW) ? pix(KW, a + D) : pix(KW, a);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic write_line(input int k, input int n, input int pause_at);
        @(negedge wck);
        wres_n = 1'b0; we_n = 1'b0; din = 8'hEE;   // R3 reset beats enable
        @(negedge wck);
        wres_n = 1'b1;
        for (int x = 0; x < n; x++) begin
            if (x == pause_at) begin               // R2 gap in the line
                we_n = 1'b1; din = 8'h5A;
                repeat (3) @(negedge wck);
            end
            we_n = 1'b0; din = 8'(pix(k, x));
            @(negedge wck);
        end
        we_n = 1'b1;
    endtask

    // mode 0: normal period k; mode 1: after long write; mode 2: read wraps
    task automatic read_line(input int k, input int n, input int mode, input int pause_at);
        logic [7:0] h0, h1;
        @(negedge rck);
        h0 = q0; h1 = q1;
        rres_n = 1'b0; re_n = 1'b0;
        @(negedge rck);
        rres_n = 1'b1;
        chk("R7 oe after reset", int'(q_oe), 0);
        chk("R7 q0 held", int'(q0), int'(h0));
        chk("R7 q1 held", int'(q1), int'(h1));
        for (int x = 0; x < n; x++) begin
            if (x == pause_at) begin
                re_n = 1'b1;
                h0 = q0; h1 = q1;
                repeat (3) @(negedge rck);
                chk("R6 oe low", int'(q_oe), 0);
                chk("R6 q0 held", int'(q0), int'(h0));
                chk("R6 q1 held", int'(q1), int'(h1));
            end
            re_n = 1'b0;
            @(negedge rck);
            chk("R4 oe high", int'(q_oe), 1);
            if (mode == 0) begin
                if (k >= 1)
                    chk((x == 0) ? "R3 R4 q0" : ((k == 4) ? "R2 R4 q0" : "R1 R4 q0"),
                        int'(q0), pix(k - 1, x));
                if (k >= 2)
                    chk("R5 q1", int'(q1), pix(k - 2, x));
            end else if (mode == 1) begin
                chk("R8 q0 write wrap", int'(q0), wrapped(x));
            end else begin
                chk("R8 q0 read wrap", int'(q0), wrapped(x % D));
                chk("R8 R5 q1 read wrap", int'(q1), wrapped(x % D));
            end
        end
        re_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge rck);
        chk("R7 reset state oe", int'(q_oe), 0);
        rres_n = 1'b1; wres_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            read_line(k, L, 0, (k == 3) ? 5 : -1);
            write_line(k, L, (k == 3) ? 7 : -1);
        end
        write_line(KW, D + NW, -1);
        read_line(0, D, 1, -1);
        read_line(0, D + 2, 2, 9);
        summary();
    end

    initial begin
        repeat (150000) @(posedge wck);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end
endmodule